// File: doc/BRIEF.md
# Programmable Interval Timer with Level Interrupt

This block is a down-counting interval timer that advances once per incoming tick strobe. The tick comes from an external microsecond tick generator and is one clock wide. Software controls the timer through two 32-bit registers. The trigger register holds three things: the start flag, the mode flag and the interval minus one. The status register reports the live count and the pending-interrupt flag, and a write to it with bit 30 set acknowledges the interrupt.

A write to the trigger register loads the counter at once, even if the timer is already running. Each tick then lowers the count by one. The tick that arrives while the count is zero is the expiry tick: it raises the interrupt. In repeating mode that tick also reloads the programmed interval. In single-shot mode it clears the start flag and the counter rests at zero. The interrupt output is a level that stays high until software acknowledges it.

Top module: `interval_timer`

## Requirements
- R1: After synchronous active-low reset the interrupt output is 0, and reads of the trigger register (byte offset 0x0) and the status register (byte offset 0x4) both return 0.
- R2: A write to offset 0x0 stores bit 31 as the start flag, bit 30 as the mode flag (1 = repeating, 0 = single-shot) and bits [28:0] as the interval. Bit 29 is discarded. A read of offset 0x0 returns {start, mode, 0, interval}.
- R3: With interval value N-1 the interrupt rises on the clock edge of the N-th tick after the write. Value 0 expires on the first tick.
- R4: In single-shot mode the start flag reads 0 after expiry, the count stays at 0, and later ticks have no effect.
- R5: In repeating mode the expiry tick reloads the interval, and counting goes on with the next tick.
- R6: Ticks are ignored while the start flag is 0. A write of zero to offset 0x0 stops the timer and clears the count.
- R7: A write to offset 0x0 while the timer is running restarts the count from the new interval. A tick in the same cycle as that write is dropped.
- R8: The interrupt is a level that stays high until a write to offset 0x4 with bit 30 = 1. A write to offset 0x4 with bit 30 = 0 leaves it set.
- R9: A read of offset 0x4 returns the live count in bits [28:0], the pending interrupt in bit 30, and 0 in bits 31 and 29.
- R10: If an expiry and an acknowledge write fall in the same cycle, the interrupt stays set.
- R11: The largest interval value, 0x1FFFFFFF, loads and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle tick strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
A register write or a tick takes effect on the first rising edge after it is presented. This holds for the new count, the start flag and the interrupt alike: the interrupt rises on the same edge as the expiry tick. Read data is combinational on the address, so a result is visible half a cycle after the edge that caused it. The bench presents every stimulus at a falling edge and keeps it for one full cycle. It samples the interrupt and the read data at the next falling edge, so each check falls exactly one edge after its stimulus. The count after any sequence of ticks is computed by stepping the requirements by hand, one tick per cycle.

// File: rtl/itmr_pkg.sv
// Package: shared constants for the interval timer.
// Holds the register offsets and the bit positions that software relies on.
package itmr_pkg;
    localparam int DATA_W   = 32;
    localparam int MAX_CW   = 29;
    localparam int OFF_TRIG = 0;
    localparam int OFF_STAT = 4;
    localparam int BIT_EN   = 31;
    localparam int BIT_MODE = 30;
    localparam int BIT_ACK  = 30;
    localparam int BIT_PEND = 30;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TRIG = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/itmr_regif.sv
// Module: itmr_regif
// Decodes register accesses: it turns a write into a load pulse or an
// acknowledge pulse and multiplexes the read data.
// Assumes: byte offsets, and a single-cycle write strobe.
module itmr_regif
    import itmr_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 4
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en_i,
    input  logic              mode_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              pend_i,
    output logic              load_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e sel;

    // Map the offset onto a register select
    always_comb begin
        if (addr_i == ADDR_W'(OFF_TRIG))      sel = SEL_TRIG;
        else if (addr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else                                  sel = SEL_NONE;
    end

    // Form the write pulses
    always_comb begin
        load_o = wr_i && (sel == SEL_TRIG);
        ack_o  = wr_i && (sel == SEL_STAT) && wdata_i[BIT_ACK];
    end

    // Assemble the read word
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_TRIG: begin
                rdata_o[BIT_EN]      = en_i;
                rdata_o[BIT_MODE]    = mode_i;
                rdata_o[CNT_W-1:0]   = reload_i;
            end
            SEL_STAT: begin
                rdata_o[BIT_PEND]    = pend_i;
                rdata_o[CNT_W-1:0]   = cnt_i;
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/itmr_cfg.sv
// Module: itmr_cfg
// Holds the start flag, the mode flag and the interval. In single-shot mode
// the start flag clears itself on expiry.
// Assumes: expiry is never signalled in a load cycle.
module itmr_cfg
    import itmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    output logic              en_o,
    output logic              mode_o,
    output logic [CNT_W-1:0]  reload_o
);
    // Store the configuration, or drop the start flag after a single-shot expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            mode_o   <= 1'b0;
            reload_o <= '0;
        end else if (load_i) begin
            en_o     <= wdata_i[BIT_EN];
            mode_o   <= wdata_i[BIT_MODE];
            reload_o <= wdata_i[CNT_W-1:0];
        end else if (expire_i && !mode_o) begin
            en_o     <= 1'b0;
        end
    end
endmodule

// File: rtl/itmr_down_counter.sv
// Module: itmr_down_counter
// Tick-driven down counter. It loads on a write, steps down once per enabled
// tick, and flags expiry on a tick that finds it at zero.
// Assumes: tick_i is at most one cycle wide for each tick.
module itmr_down_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic at_zero;

    // Detect expiry; a load in the same cycle takes priority and drops the tick
    always_comb begin
        at_zero  = (cnt_o == '0);
        expire_o = tick_i && en_i && at_zero && !load_i;
    end

    // Update the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= load_val_i;
        end else if (tick_i && en_i) begin
            if (at_zero) cnt_o <= mode_i ? reload_i : '0;
            else         cnt_o <= cnt_o - 1'b1;
        end
    end
endmodule

// File: rtl/itmr_irq_flag.sv
// Module: itmr_irq_flag
// Pending-interrupt flag: it is set by expiry and cleared by an acknowledge,
// and set wins when both come in the same cycle.
// Assumes: both inputs are single-cycle pulses.
module itmr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Hold the level until it is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer (top)
// Interval timer with a trigger register (offset 0x0), a status/acknowledge
// register (offset 0x4) and a level interrupt.
// Assumes: the tick strobe is synchronous to clk; CNT_W is at most 29.
module interval_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    logic             load_pulse;
    logic             ack_pulse;
    logic             expire;
    logic             en_q;
    logic             mode_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    itmr_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .en_i     (en_q),
        .mode_i   (mode_q),
        .reload_i (reload_q),
        .cnt_i    (cnt_q),
        .pend_i   (irq_o),
        .load_o   (load_pulse),
        .ack_o    (ack_pulse),
        .rdata_o  (reg_rdata_o)
    );

    itmr_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_pulse),
        .wdata_i  (reg_wdata_i),
        .expire_i (expire),
        .en_o     (en_q),
        .mode_o   (mode_q),
        .reload_o (reload_q)
    );

    itmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (en_q),
        .mode_i     (mode_q),
        .load_i     (load_pulse),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .reload_i   (reload_q),
        .cnt_o      (cnt_q),
        .expire_o   (expire)
    );

    itmr_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .clr_i  (ack_pulse),
        .pend_o (irq_o)
    );
endmodule

// File: rtl/interval_timer_chk.sv
// Module: interval_timer_chk
// Property checker bound to interval_timer. It decodes the register writes
// from the ports on its own and checks them against the internal state.
module interval_timer_chk #(
    parameter int CNT_W  = 29,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic              en,
    input logic              mode,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  cnt
);
    logic wr_trig, wr_ack, fire;
    assign wr_trig = wr && (addr == ADDR_W'(0));
    assign wr_ack  = wr && (addr == ADDR_W'(4)) && wdata[30];
    assign fire    = tick && en && (cnt == '0) && !wr_trig;

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trig |=> (cnt == $past(wdata[CNT_W-1:0])));
    assert_expire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq);
    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mode) |=> (!en && cnt == '0));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode) |=> (cnt == $past(reload) && en));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_trig) |=> $stable(cnt));
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ack) |=> irq);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !fire) |=> !irq);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && fire) |=> irq);
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i),
    .irq    (irq_o),
    .en     (en_q),
    .mode   (mode_q),
    .reload (reload_q),
    .cnt    (cnt_q)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] r;

    always #10 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [28:0] cm1;
        logic        per;
        logic [7:0]  nt;
        logic        xirq;
        logic [28:0] xcnt;
        logic        xen;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{29'd3, 1'b0, 8'd3, 1'b0, 29'd0, 1'b1},
        '{29'd3, 1'b0, 8'd4, 1'b1, 29'd0, 1'b0},
        '{29'd3, 1'b0, 8'd6, 1'b1, 29'd0, 1'b0},
        '{29'd2, 1'b1, 8'd3, 1'b1, 29'd2, 1'b1},
        '{29'd2, 1'b1, 8'd5, 1'b1, 29'd0, 1'b1},
        '{29'd0, 1'b0, 8'd1, 1'b1, 29'd0, 1'b0},
        '{29'd0, 1'b1, 8'd2, 1'b1, 29'd0, 1'b1},
        '{29'd5, 1'b1, 8'd0, 1'b0, 29'd5, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Present inputs at a falling edge for one full cycle
    task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
        tick = t; wr = w; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
        addr = '0;
    endtask

    task automatic idle_reset;
        cyc(1'b0, 1'b1, 4'h0, 32'h0);
        cyc(1'b0, 1'b1, 4'h4, 32'h4000_0000);
    endtask

    initial begin
        #4_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(4'h0, r); check("R1 trig", r, 32'h0);
        rd(4'h4, r); check("R1 stat", r, 32'h0);

        // Vector table: R3 R4 R5
        foreach (VEC[i]) begin
            idle_reset();
            cyc(1'b0, 1'b1, 4'h0, {1'b1, VEC[i].per, 1'b0, VEC[i].cm1});
            ticks(int'(VEC[i].nt));
            check("R3 vec irq", {31'h0, irq}, {31'h0, VEC[i].xirq});
            rd(4'h4, r); check("R5 vec count", {3'b0, r[28:0]}, {3'b0, VEC[i].xcnt});
            rd(4'h0, r); check("R4 vec enable", {31'h0, r[31]}, {31'h0, VEC[i].xen});
        end

        // R2 R11 max value, bit 29 discarded
        idle_reset();
        cyc(1'b0, 1'b1, 4'h0, 32'hFFFF_FFFF);
        rd(4'h0, r); check("R2 trig readback", r, 32'hDFFF_FFFF);
        ticks(1);
        rd(4'h4, r); check("R11 max count step", r, 32'h1FFF_FFFE);

        // R6 write of zero stops
        idle_reset();
        cyc(1'b0, 1'b1, 4'h0, 32'h8000_0005);
        ticks(2);
        rd(4'h4, r); check("R6 running count", r, 32'h0000_0003);
        cyc(1'b0, 1'b1, 4'h0, 32'h0);
        ticks(3);
        check("R6 stopped irq", {31'h0, irq}, 32'h0);
        rd(4'h4, r); check("R6 stopped status", r, 32'h0);
        // R6 disabled load ignores ticks
        cyc(1'b0, 1'b1, 4'h0, 32'h0000_0005);
        ticks(3);
        rd(4'h4, r); check("R6 disabled hold", r, 32'h0000_0005);

        // R7 restart with a tick in the same cycle
        idle_reset();
        cyc(1'b0, 1'b1, 4'h0, 32'h8000_0004);
        ticks(3);
        cyc(1'b1, 1'b1, 4'h0, 32'h8000_0004);
        rd(4'h4, r); check("R7 restart count", r, 32'h0000_0004);
        ticks(4);
        check("R7 no early irq", {31'h0, irq}, 32'h0);
        ticks(1);
        check("R7 irq after restart", {31'h0, irq}, 32'h1);

        // R8 R9 acknowledge
        cyc(1'b0, 1'b1, 4'h4, 32'hBFFF_FFFF);
        check("R8 ack bit clear keeps irq", {31'h0, irq}, 32'h1);
        rd(4'h4, r); check("R9 status word", r, 32'h4000_0000);
        cyc(1'b0, 1'b1, 4'h4, 32'h4000_0000);
        check("R8 ack clears irq", {31'h0, irq}, 32'h0);

        // R10 expiry and acknowledge in the same cycle
        idle_reset();
        cyc(1'b0, 1'b1, 4'h0, 32'h8000_0000);
        cyc(1'b1, 1'b1, 4'h4, 32'h4000_0000);
        check("R10 set wins", {31'h0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule